// File: doc/BRIEF.md
# Banked Cyclic Lane Rotator

This block turns a wide vector of soft-value lanes by a run-time shift amount, so that the lanes line up with one block entry of a quasi-cyclic parity-check matrix. The lanes are grouped in banks of 27. The active modulus is 27, 54 or 81 lanes, which is one, two or three banks. The same block serves the read side, where it applies the entry's forward rotation, and the write-back side, where the inverse rotation puts the lanes back in their original order.

Each cycle may carry one rotation. The result is registered with one cycle of latency. A registered enable output for each bank reports which banks carry live data, so the neighbouring memories and compute lanes can gate their clocks. Lanes above the active size are forced to zero.

Top module: `rotnet_top`

## Requirements
- R1: Lane 0 sits in bits [LANE_W-1:0] of `din` and `dout`, and lane i in the next slice upward. With `inv`=0, output lane i (for i < Z) equals input lane (i + s) mod Z, where s is `shift`.
- R2: With `inv`=1, output lane i (for i < Z) equals input lane (i - s mod Z + Z) mod Z.
- R3: A shift value of Z or larger gives the same result as the shift value reduced modulo Z.
- R4: A shift of 0 passes lanes 0..Z-1 through unchanged in either direction.
- R5: `zsel` gives the number of active banks, with Z = 27 times `zsel`. A value of 1, 2 or 3 selects Z = 27, 54 or 81. A value of 0 makes every output lane zero. Output lanes at index Z and above are zero.
- R6: `bank_en` bit b is 1 exactly when b < `zsel`. It is registered in the same cycle as the data it describes.
- R7: `vld_out` equals `vld_in` delayed by one clock, and the data for a valid input appears on `dout` on that same edge.
- R8: While `vld_in` is 0, `dout` and `bank_en` hold their previous values.
- R9: While reset is held and after it is released, before any valid input, `vld_out`, `dout` and `bank_en` are all zero.
- R10: A forward rotation by s followed by an inverse rotation by s under the same `zsel` returns the original lanes 0..Z-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vld_in | input | 1 | Input vector and controls are valid this cycle |
| zsel | input | 2 | Active bank count (0..3) |
| shift | input | 7 | Rotation amount from the matrix entry |
| inv | input | 1 | 0 = forward rotation, 1 = inverse rotation |
| din | input | 648 | 81 lanes of 8 bits |
| vld_out | output | 1 | Output vector valid |
| dout | output | 648 | Rotated lanes, zero above Z |
| bank_en | output | 3 | Registered per-bank activity enables |

## Verification
The embedded properties are checked on every cycle. They cover the one-cycle valid delay, holding of data and enables while idle, the thermometer form of the bank enables, zero lanes in every bank reported off, and pass-through of a zero shift at full width. The lane mapping itself can only be shown by the bench's scenarios. The bench sweeps every shift value from 0 to 127 in both directions for each bank count, covers the all-off selection, and runs forward-then-inverse round trips. Reduction of oversized shifts and the exact source lane for each output lane are judged there against arithmetic in the bench.

// File: rtl/rotnet_pkg.sv
package rotnet_pkg;
  localparam int LANE_W     = 8;
  localparam int BANK_LANES = 27;
  localparam int NBANKS     = 3;
  localparam int MAX_LANES  = BANK_LANES * NBANKS;
  localparam int SHIFT_W    = 7;
  localparam int CODE_W     = $clog2(NBANKS + 1);
  localparam int VEC_W      = MAX_LANES * LANE_W;
endpackage

// File: rtl/rotnet_lane_rot.sv
// Rotates a fixed-size group of lanes by (shift mod LANES), forward or inverse.
module rotnet_lane_rot #(
  parameter int LANES   = 27,
  parameter int W       = 8,
  parameter int SHIFT_W = 7
) (
  input  logic [LANES*W-1:0] din,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               inv,
  output logic [LANES*W-1:0] dout
);
  localparam int KW = $clog2(LANES);
  localparam int DW = 2 * LANES * W;

  logic [KW-1:0] k_fwd;
  logic [KW-1:0] k_eff;
  logic [DW-1:0] stg [KW+1];

  // reduce the shift modulo the group size, then turn an inverse into a forward amount
  always_comb begin
    int unsigned red;
    red   = 32'(shift) % 32'(LANES);
    k_fwd = KW'(red);
    if (inv && (red != 0)) k_eff = KW'(32'(LANES) - red);
    else                   k_eff = k_fwd;
  end

  // logarithmic shifter over a doubled copy: low LANES lanes form the rotation
  assign stg[0] = {din, din};
  for (genvar j = 0; j < KW; j++) begin : g_stage
    assign stg[j+1] = k_eff[j] ? (stg[j] >> (W * (2 ** j))) : stg[j];
  end

  assign dout = stg[KW][LANES*W-1:0];
endmodule

// File: rtl/rotnet_bank_dec.sv
// Converts an active-bank count into a thermometer of bank enables.
module rotnet_bank_dec #(
  parameter int NBANKS = 3,
  parameter int CODE_W = 2
) (
  input  logic [CODE_W-1:0] code,
  output logic [NBANKS-1:0] en
);
  for (genvar b = 0; b < NBANKS; b++) begin : g_en
    assign en[b] = (32'(code) > b);
  end
endmodule

// File: rtl/rotnet_top.sv
module rotnet_top
  import rotnet_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_in,
  input  logic [CODE_W-1:0]    zsel,
  input  logic [SHIFT_W-1:0]   shift,
  input  logic                 inv,
  input  logic [VEC_W-1:0]     din,
  output logic                 vld_out,
  output logic [VEC_W-1:0]     dout,
  output logic [NBANKS-1:0]    bank_en
);
  // reset synchroniser: asserts at once, releases on the second clock
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  // one rotator per possible active size
  logic [VEC_W-1:0] rot_full [NBANKS];
  for (genvar b = 0; b < NBANKS; b++) begin : g_rot
    localparam int GL = (b + 1) * BANK_LANES;
    logic [GL*LANE_W-1:0] rot_part;
    rotnet_lane_rot #(.LANES(GL), .W(LANE_W), .SHIFT_W(SHIFT_W)) u_rot (
      .din   (din[GL*LANE_W-1:0]),
      .shift (shift),
      .inv   (inv),
      .dout  (rot_part)
    );
    assign rot_full[b] = VEC_W'(rot_part);
  end

  logic [NBANKS-1:0] ben_d;
  rotnet_bank_dec #(.NBANKS(NBANKS), .CODE_W(CODE_W)) u_dec (
    .code (zsel),
    .en   (ben_d)
  );

  // next-state selection
  logic [VEC_W-1:0] dout_d;
  always_comb begin
    dout_d = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (32'(zsel) == b + 1) dout_d = rot_full[b];
    end
    if (32'(zsel) > NBANKS) dout_d = rot_full[NBANKS-1];
  end

  // registers: valid every cycle, data and enables under clock enable
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) vld_out <= 1'b0;
    else       vld_out <= vld_in;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      dout    <= '0;
      bank_en <= '0;
    end else if (vld_in) begin
      dout    <= dout_d;
      bank_en <= ben_d;
    end
  end

  // ---------------- assertions ----------------
  p_valid_set_r7: assert property (@(posedge clk) disable iff (!rs_n)
    vld_in |=> vld_out);
  p_valid_clr_r7: assert property (@(posedge clk) disable iff (!rs_n)
    !vld_in |=> !vld_out);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rs_n)
    !vld_in |=> ($stable(dout) && $stable(bank_en)));
  p_ben_thermo_r6: assert property (@(posedge clk) disable iff (!rs_n)
    ((bank_en + 1'b1) & bank_en) == '0);
  p_zero_shift_r4: assert property (@(posedge clk) disable iff (!rs_n)
    (vld_in && shift == '0 && 32'(zsel) == NBANKS) |=> dout == $past(din));
  for (genvar b = 0; b < NBANKS; b++) begin : g_offchk
    p_off_bank_zero_r5: assert property (@(posedge clk) disable iff (!rs_n)
      !bank_en[b] |-> dout[(b+1)*BANK_LANES*LANE_W-1 : b*BANK_LANES*LANE_W] == '0);
  end
endmodule

// File: tb/tb_rotnet_top.sv
module tb_rotnet_top;
  import rotnet_pkg::*;
  localparam time CLK_PERIOD = 10ns;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               vld_in;
  logic [CODE_W-1:0]  zsel;
  logic [SHIFT_W-1:0] shift;
  logic               inv;
  logic [VEC_W-1:0]   din;
  logic               vld_out;
  logic [VEC_W-1:0]   dout;
  logic [NBANKS-1:0]  bank_en;

  int checks = 0;
  int errors = 0;

  rotnet_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [LANE_W-1:0] lane_of(input logic [VEC_W-1:0] v, input int i);
    return v[i*LANE_W +: LANE_W];
  endfunction

  function automatic logic [VEC_W-1:0] pattern(input int seed);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < MAX_LANES; i++) v[i*LANE_W +: LANE_W] = LANE_W'(i * 37 + seed * 11 + 5);
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] model(input logic [VEC_W-1:0] v, input int nb,
                                             input int s, input bit dir);
    logic [VEC_W-1:0] r = '0;
    int z = nb * BANK_LANES;
    for (int i = 0; i < z; i++) begin
      int src;
      if (dir) src = (i - (s % z) + z) % z;
      else     src = (i + s) % z;
      r[i*LANE_W +: LANE_W] = lane_of(v, src);
    end
    return r;
  endfunction

  task automatic check_vec(input string tag, input logic [VEC_W-1:0] act,
                           input logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      for (int i = 0; i < MAX_LANES; i++)
        if (lane_of(act, i) !== lane_of(exp, i)) begin
          $display("FAIL %s lane %0d actual %0h expected %0h", tag, i,
                   lane_of(act, i), lane_of(exp, i));
          break;
        end
    end
  endtask

  task automatic check_bits(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at negedge; the next posedge loads; sample at the following negedge
  task automatic apply(input int nb, input int s, input bit dir, input logic [VEC_W-1:0] v);
    @(negedge clk);
    vld_in = 1'b1; zsel = CODE_W'(nb); shift = SHIFT_W'(s); inv = dir; din = v;
    @(negedge clk);
    vld_in = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [VEC_W-1:0] v, fwd, snap;
    rst_n = 1'b0; vld_in = 1'b0; zsel = '0; shift = '0; inv = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    // R9: state during reset
    check_bits("R9 vld_out in reset", 32'(vld_out), 0);
    check_vec ("R9 dout in reset", dout, '0);
    check_bits("R9 bank_en in reset", 32'(bank_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bits("R9 vld_out after release", 32'(vld_out), 0);
    check_vec ("R9 dout after release", dout, '0);

    // R1..R4, R6, R7: full sweep over sizes, directions and shift values
    for (int nb = 1; nb <= NBANKS; nb++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < (1 << SHIFT_W); s++) begin
          string tag;
          v = pattern(s + d * 131 + nb * 7);
          apply(nb, s, bit'(d), v);
          if (s == 0)                    tag = "R4 zero shift";
          else if (s >= nb * BANK_LANES) tag = "R3 oversized shift";
          else if (d == 1)               tag = "R2 inverse";
          else                           tag = "R1 forward";
          check_vec(tag, dout, model(v, nb, s, bit'(d)));
          check_bits("R7 vld_out", 32'(vld_out), 1);
          check_bits("R6 bank_en", 32'(bank_en), (1 << nb) - 1);
        end

    // R5: zero lanes above Z and the all-off selection
    apply(1, 5, 1'b0, pattern(99));
    for (int i = BANK_LANES; i < MAX_LANES; i++)
      check_bits("R5 lane above Z", 32'(lane_of(dout, i)), 0);
    apply(0, 9, 1'b0, pattern(3));
    check_vec ("R5 zsel 0 all zero", dout, '0);
    check_bits("R6 bank_en zsel 0", 32'(bank_en), 0);

    // R7, R8: idle cycles hold data and enables, valid drops
    apply(2, 17, 1'b1, pattern(42));
    snap = dout;
    @(negedge clk);
    check_bits("R7 vld_out idle", 32'(vld_out), 0);
    zsel = 2'd3; din = pattern(77); shift = 7'd3;
    repeat (3) @(negedge clk);
    check_vec ("R8 hold dout", dout, snap);
    check_bits("R8 hold bank_en", 32'(bank_en), 3);

    // R10: forward then inverse restores the lanes
    for (int nb = 1; nb <= NBANKS; nb++)
      for (int s = 0; s < (1 << SHIFT_W); s += 13) begin
        v = pattern(s * 3 + nb);
        apply(nb, s, 1'b0, v);
        fwd = dout;
        apply(nb, s, 1'b1, fwd);
        check_vec("R10 round trip", dout, model(v, nb, 0, 1'b0));
      end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule